// File: doc/BRIEF.md
# Filtered Input Capture Channel

This block is one capture channel that sits beside a 16-bit timer counter. A digital signal enters the channel and is registered once, then passed through a glitch filter. The filter accepts a new level only after that level has been seen on a programmable number of consecutive clock samples. Level changes that survive the filter become rising or falling edge events. A polarity setting picks which of those events count. A prescaler then passes only every first, second, fourth or eighth counted event.

Each event that gets through the prescaler copies the timer count presented on `count_i` into a read-only capture register and sets a capture flag. If the capture flag is still set when a new capture arrives, an over-capture flag is raised as well. Software clears each flag with its own single-cycle write-one strobe. The timer counter, the bus interface and any output-compare use of the channel are outside this block.

Top module: `icap_channel`

## Requirements
- R1: While `rst_n` is low and after it is released, `cap_value` is 0, `cap_flag` is 0, `ovr_flag` is 0, and the filtered level starts at 0.
- R2: `filt_sel` sets the filter length N: 00 gives N=1 (no filtering), 01 gives 2, 10 gives 4 and 11 gives 8. A level change is accepted only after N consecutive samples of the new level. A pulse shorter than N samples produces no event.
- R3: `pol_sel` selects the edges that count: 00 selects rising, 01 selects falling, 11 selects both, and 10 selects none.
- R4: `psc_sel` makes every 1st (00), 2nd (01), 4th (10) or 8th (11) selected edge cause a capture. The event count restarts whenever capture is disabled.
- R5: Suppose a new level is first sampled at clock edge k and is then held. The capture happens at edge k+N+1. At that edge `cap_value` loads the value on `count_i`. Between captures `cap_value` holds its value.
- R6: A capture sets `cap_flag`. A capture that arrives while `cap_flag` is already 1 also sets `ovr_flag`.
- R7: A one-cycle pulse on `clr_cap` clears `cap_flag`, and a pulse on `clr_ovr` clears `ovr_flag`. If a capture and a clear fall in the same cycle, the capture wins.
- R8: While `cap_en` is 0 or `input_mode` is 0, no capture is stored and neither flag is set. In particular, `ovr_flag` can only be set in input mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_in | input | 1 | Signal to capture on, already synchronous to `clk` |
| count_i | input | 16 | Current timer count |
| input_mode | input | 1 | Channel is in input capture mode |
| cap_en | input | 1 | Allow captures to be stored |
| filt_sel | input | 2 | Filter length select |
| psc_sel | input | 2 | Event prescaler select |
| pol_sel | input | 2 | Active edge select |
| clr_cap | input | 1 | Write-one clear strobe for the capture flag |
| clr_ovr | input | 1 | Write-one clear strobe for the over-capture flag |
| cap_value | output | 16 | Count latched at the most recent capture |
| cap_flag | output | 1 | Capture flag |
| ovr_flag | output | 1 | Over-capture flag |

## Verification
The assertions assume that `psc_sel` changes only while capture is disabled. This keeps the prescaler's event count below the newly selected ratio. The stimulus respects this by dropping `cap_en` for two cycles around every configuration change. The assertions also assume that the clear strobes are single-cycle pulses, and the stimulus drives them that way. The filter and polarity settings may change at any time, because the assertions relate only the internal edge, event and capture wires to the flags and the captured value.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [1:0] {
    POL_RISE = 2'b00,
    POL_FALL = 2'b01,
    POL_NONE = 2'b10,
    POL_BOTH = 2'b11
  } icap_pol_e;

  // Number of equal samples that the filter needs before it accepts a new level.
  function automatic int filt_len(input int sel);
    return 1 << sel;
  endfunction

  // Number of selected edges that make up one capture.
  function automatic int psc_ratio(input int sel);
    return 1 << sel;
  endfunction

  // Picks the edge pulses that the polarity setting selects.
  function automatic logic pol_pick(input logic [1:0] pol, input logic rise, input logic fall);
    logic r;
    case (pol)
      POL_RISE: r = rise;
      POL_FALL: r = fall;
      POL_BOTH: r = rise | fall;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/icap_glitch_filter.sv
module icap_glitch_filter #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             rise_o,
  output logic             fall_o
);
  import icap_pkg::*;

  localparam int RUN_W = (1 << SEL_W) - 1;

  logic             lvl_q;
  logic [RUN_W-1:0] run_q;
  logic             accept_w;

  assign accept_w = (smp_i != lvl_q) && ((int'(run_q) + 1) >= filt_len(int'(sel_i)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      run_q  <= '0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= accept_w & smp_i;
      fall_o <= accept_w & ~smp_i;
      if (smp_i == lvl_q) begin
        run_q <= '0;
      end else if (accept_w) begin
        lvl_q <= smp_i;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/icap_event_gate.sv
module icap_event_gate #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [1:0]       pol_i,
  input  logic [SEL_W-1:0] psc_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             evt_o,
  output logic             fire_o
);
  import icap_pkg::*;

  localparam int PC_W = (1 << SEL_W) - 1;

  logic [PC_W-1:0] pcnt_q;

  assign evt_o  = pol_pick(pol_i, rise_i, fall_i);
  assign fire_o = enable_i && evt_o && ((int'(pcnt_q) + 1) >= psc_ratio(int'(psc_i)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (!enable_i) begin
      pcnt_q <= '0;
    end else if (evt_o) begin
      pcnt_q <= fire_o ? '0 : pcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/icap_capture_reg.sv
module icap_capture_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             clr_cap_i,
  input  logic             clr_ovr_i,
  output logic [CNT_W-1:0] value_o,
  output logic             cap_o,
  output logic             ovr_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value_o <= '0;
      cap_o   <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      if (fire_i) value_o <= count_i;
      if (fire_i)         cap_o <= 1'b1;
      else if (clr_cap_i) cap_o <= 1'b0;
      if (fire_i && cap_o) ovr_o <= 1'b1;
      else if (clr_ovr_i)  ovr_o <= 1'b0;
    end
  end

endmodule

// File: rtl/icap_channel.sv
module icap_channel #(
  parameter int CNT_W  = 16,
  parameter int FILT_W = 2,
  parameter int PSC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_in,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              input_mode,
  input  logic              cap_en,
  input  logic [FILT_W-1:0] filt_sel,
  input  logic [PSC_W-1:0]  psc_sel,
  input  logic [1:0]        pol_sel,
  input  logic              clr_cap,
  input  logic              clr_ovr,
  output logic [CNT_W-1:0]  cap_value,
  output logic              cap_flag,
  output logic              ovr_flag
);

  logic smp_q;
  logic rise_w;
  logic fall_w;
  logic evt_w;
  logic fire_w;
  logic gate_en_w;

  assign gate_en_w = cap_en & input_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) smp_q <= 1'b0;
    else        smp_q <= cap_in;
  end

  icap_glitch_filter #(.SEL_W(FILT_W)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_i  (smp_q),
    .sel_i  (filt_sel),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  icap_event_gate #(.SEL_W(PSC_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (gate_en_w),
    .pol_i    (pol_sel),
    .psc_i    (psc_sel),
    .rise_i   (rise_w),
    .fall_i   (fall_w),
    .evt_o    (evt_w),
    .fire_o   (fire_w)
  );

  icap_capture_reg #(.CNT_W(CNT_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (fire_w),
    .count_i   (count_i),
    .clr_cap_i (clr_cap),
    .clr_ovr_i (clr_ovr),
    .value_o   (cap_value),
    .cap_o     (cap_flag),
    .ovr_o     (ovr_flag)
  );

endmodule

// File: rtl/icap_channel_chk.sv
module icap_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count_i,
  input logic             input_mode,
  input logic             cap_en,
  input logic [1:0]       pol_sel,
  input logic             clr_cap,
  input logic             clr_ovr,
  input logic             rise_w,
  input logic             fall_w,
  input logic             evt_w,
  input logic             fire_w,
  input logic [CNT_W-1:0] cap_value,
  input logic             cap_flag,
  input logic             ovr_flag
);

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({rise_w, fall_w})); // R2
  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (evt_w && pol_sel == 2'b00) |-> rise_w); // R3
  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (evt_w && pol_sel == 2'b01) |-> fall_w); // R3
  AST_NONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (pol_sel == 2'b10) |-> !evt_w); // R3
  AST_FIRE_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n) fire_w |-> evt_w); // R4
  AST_VALUE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) fire_w |=> cap_value == $past(count_i)); // R5
  AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !fire_w |=> $stable(cap_value)); // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) fire_w |=> cap_flag); // R6
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n) (fire_w && cap_flag) |=> ovr_flag); // R6
  AST_CAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (clr_cap && !fire_w) |=> !cap_flag); // R7
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (clr_ovr && !(fire_w && cap_flag)) |=> !ovr_flag); // R7
  AST_NO_CAP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) !(cap_en && input_mode) |-> !fire_w); // R8
  AST_OVR_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovr_flag) |-> $past(input_mode)); // R8

endmodule

bind icap_channel icap_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .count_i    (count_i),
  .input_mode (input_mode),
  .cap_en     (cap_en),
  .pol_sel    (pol_sel),
  .clr_cap    (clr_cap),
  .clr_ovr    (clr_ovr),
  .rise_w     (rise_w),
  .fall_w     (fall_w),
  .evt_w      (evt_w),
  .fire_w     (fire_w),
  .cap_value  (cap_value),
  .cap_flag   (cap_flag),
  .ovr_flag   (ovr_flag)
);

// File: tb/icap_channel_tb.sv
`timescale 1ns/1ps
module icap_channel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_in = 1'b0;
  logic [15:0] count_i = '0;
  logic        input_mode = 1'b0;
  logic        cap_en = 1'b0;
  logic [1:0]  filt_sel = '0;
  logic [1:0]  psc_sel = '0;
  logic [1:0]  pol_sel = '0;
  logic        clr_cap = 1'b0;
  logic        clr_ovr = 1'b0;
  logic [15:0] cap_value;
  logic        cap_flag;
  logic        ovr_flag;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic        hold_cnt = 1'b0;
  logic [15:0] hold_val = '0;
  logic [15:0] saved;

  always #2.5 clk = ~clk;

  icap_channel u_dut (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .count_i(count_i),
    .input_mode(input_mode), .cap_en(cap_en), .filt_sel(filt_sel),
    .psc_sel(psc_sel), .pol_sel(pol_sel), .clr_cap(clr_cap), .clr_ovr(clr_ovr),
    .cap_value(cap_value), .cap_flag(cap_flag), .ovr_flag(ovr_flag)
  );

  // Timer count stand-in: free running, or frozen for directed value checks.
  always @(negedge clk) count_i <= hold_cnt ? hold_val : count_i + 16'd1;

  // ---------------- reference model, restated from the requirements ----------------
  logic        m_smp, m_lvl, m_rise, m_fall, m_cf, m_of;
  logic [7:0]  m_hist;
  logic [15:0] m_val;
  int          m_pc;

  function automatic logic run_complete(input logic [7:0] h, input logic lvl, input int n);
    for (int i = 0; i < n; i++) if (h[i] == lvl) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic edge_wanted(input logic [1:0] p, input logic r, input logic f);
    return (p == 2'b00 && r) || (p == 2'b01 && f) || (p == 2'b11 && (r || f));
  endfunction

  always @(posedge clk) begin
    logic [7:0] h;
    logic fire;
    if (!rst_n) begin
      m_smp <= 0; m_lvl <= 0; m_rise <= 0; m_fall <= 0; m_cf <= 0; m_of <= 0;
      m_hist <= '0; m_val <= '0; m_pc = 0;
    end else begin
      m_smp <= cap_in;
      h = {m_hist[6:0], m_smp};
      m_hist <= h;
      m_rise <= 0; m_fall <= 0;
      if (run_complete(h, m_lvl, 1 << filt_sel)) begin
        m_lvl <= ~m_lvl; m_rise <= ~m_lvl; m_fall <= m_lvl;
      end
      fire = 0;
      if (!(cap_en && input_mode)) m_pc = 0;
      else if (edge_wanted(pol_sel, m_rise, m_fall)) begin
        if (m_pc + 1 == (1 << psc_sel)) begin fire = 1; m_pc = 0; end
        else m_pc = m_pc + 1;
      end
      if (fire) begin
        m_val <= count_i; m_cf <= 1;
        if (m_cf) m_of <= 1; else if (clr_ovr) m_of <= 0;
      end else begin
        if (clr_cap) m_cf <= 0;
        if (clr_ovr) m_of <= 0;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R5", "model cap_value", cap_value, m_val);
    chk("R6", "model cap_flag", cap_flag, m_cf);
    chk("R6", "model ovr_flag", ovr_flag, m_of);
  end

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] f, input logic [1:0] p, input logic [1:0] pol);
    cap_en = 0; step(1);
    filt_sel = f; psc_sel = p; pol_sel = pol; step(1);
    cap_en = 1;
  endtask

  task automatic clear_all();
    clr_cap = 1; clr_ovr = 1; step(1);
    clr_cap = 0; clr_ovr = 0; step(1);
  endtask

  task automatic pulse(input int hi, input int lo);
    cap_in = 1; step(hi);
    cap_in = 0; step(lo);
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    step(3);
    chk("R1", "cap_value in reset", cap_value, 0);
    chk("R1", "cap_flag in reset", cap_flag, 0);
    chk("R1", "ovr_flag in reset", ovr_flag, 0);
    rst_n = 1; step(2);
    chk("R1", "cap_flag after reset", cap_flag, 0);

    input_mode = 1;
    cfg(2'b00, 2'b00, 2'b00);
    step(2);
    // R5: frozen count is captured on a rising edge
    hold_val = 16'h1234; hold_cnt = 1;
    pulse(4, 4);
    chk("R5", "captured value", cap_value, 16'h1234);
    chk("R6", "cap_flag after capture", cap_flag, 1);
    chk("R3", "falling edge ignored in rising mode", ovr_flag, 0);
    hold_cnt = 0;
    // R7 clear
    clear_all();
    chk("R7", "cap_flag cleared", cap_flag, 0);
    // R6 over-capture
    pulse(3, 3); pulse(3, 3);
    chk("R6", "ovr_flag after second capture", ovr_flag, 1);
    clear_all();
    chk("R7", "ovr_flag cleared", ovr_flag, 0);
    // R7 collision: capture at 2nd edge after first sample, clear in same cycle
    cap_in = 1; step(2);
    clr_cap = 1; step(1);
    clr_cap = 0;
    chk("R7", "capture beats clear", cap_flag, 1);
    cap_in = 0; step(4);
    clear_all();
    // R2: 8-sample filter rejects a 7-cycle pulse, accepts a long one
    cfg(2'b11, 2'b00, 2'b00);
    pulse(7, 12);
    chk("R2", "short pulse filtered", cap_flag, 0);
    cap_in = 1; step(12);
    chk("R2", "long level accepted", cap_flag, 1);
    clear_all();
    // R3 falling / both
    cfg(2'b00, 2'b00, 2'b01);
    cap_in = 0; step(5);
    chk("R3", "falling captured", cap_flag, 1);
    clear_all();
    cap_in = 1; step(5);
    chk("R3", "rising ignored in falling mode", cap_flag, 0);
    cfg(2'b00, 2'b00, 2'b11);
    cap_in = 0; step(5);
    chk("R3", "both-edges mode captures fall", cap_flag, 1);
    clear_all();
    cfg(2'b00, 2'b00, 2'b10);
    pulse(4, 4);
    chk("R3", "none mode silent", cap_flag, 0);
    // R4 prescaler by 4
    cfg(2'b00, 2'b10, 2'b00);
    pulse(3, 3); pulse(3, 3); pulse(3, 3);
    chk("R4", "three edges below ratio", cap_flag, 0);
    pulse(3, 3);
    chk("R4", "fourth edge captures", cap_flag, 1);
    clear_all();
    // R8 disabled capture
    cfg(2'b00, 2'b00, 2'b00);
    saved = cap_value;
    cap_en = 0;
    pulse(3, 3); pulse(3, 3);
    chk("R8", "no flag while disabled", cap_flag, 0);
    chk("R8", "value held while disabled", cap_value, saved);
    cap_en = 1;
    pulse(3, 3);
    chk("R8", "capture after re-enable", cap_flag, 1);
    saved = cap_value;
    input_mode = 0;
    pulse(3, 3); pulse(3, 3);
    chk("R8", "no over-capture outside input mode", ovr_flag, 0);
    chk("R8", "value held outside input mode", cap_value, saved);
    input_mode = 1;
    clear_all();

    // random phase against the model
    for (int b = 0; b < 40; b++) begin
      cfg(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
      input_mode = ($urandom_range(0, 7) != 0);
      for (int c = 0; c < 80; c++) begin
        if ($urandom_range(0, 5) == 0) cap_in = ~cap_in;
        if ($urandom_range(0, 15) == 0) cap_in = ~cap_in;
        clr_cap = ($urandom_range(0, 9) == 0);
        clr_ovr = ($urandom_range(0, 9) == 0);
        step(1);
      end
      clr_cap = 0; clr_ovr = 0;
    end
    step(2);
    report();
  end

endmodule